// File: doc/BRIEF.md
# Bus-Controlled Pin Port with Masked Output Writes

This block is a bank of 32 general-purpose pins controlled from a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. The pad side is modelled as an output-enable vector, an output-level vector and a raw input vector.

Pin direction never needs a read-modify-write. One address turns the selected pins into outputs and a second address turns them back into inputs. Bits written as zero leave their pins alone.

Output levels live in two half-bank registers of 16 pins each. Every write to one of them carries its own 16-bit mask in the upper half-word, so a single pin's level can be changed in one bus cycle without disturbing its neighbours. The stored level is independent of direction. Software can preload a level while the pin is still an input, and the pin then drives that level from the first cycle its enable rises.

Raw pad inputs pass through a two-stage synchronizer before they can be read.

Top module: `pinbank_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all zero) and every stored output level is zero (`pad_out` all zero).
- R2: A write to address 0x00 sets `pad_oe[n]` for each data bit n that is 1. Enable bits whose data bit is 0 keep their value. The change is visible after the clock edge that takes the write.
- R3: A write to address 0x04 clears `pad_oe[n]` for each data bit n that is 1. Enable bits whose data bit is 0 keep their value.
- R4: A write to address 0x08 updates the levels of pins 0..15. Data bit 16+k is the mask for pin k and data bit k is its new level. Only pins whose mask bit is 1 change.
- R5: A write to address 0x0C updates pins 16..31 in the same way. Data bit 16+k masks pin 16+k and data bit k gives its level. A write with an all-zero mask changes nothing.
- R6: Stored output levels are kept whatever the direction. A level written while a pin is an input appears on `pad_out` at once, and it is present in the same cycle that `pad_oe` for that pin rises.
- R7: Reading address 0x10 returns the pad inputs, with bit n for pin n, delayed through two flops. A change on `pad_in` is not visible after one clock edge and is visible after the second.
- R8: Reading 0x00 or 0x04 returns the current `pad_oe` vector. Reading 0x08 or 0x0C returns the 16 stored levels of that half in bits 15:0 and zero in bits 31:16.
- R9: Reading any other address returns zero. Writes to any other address, including the read-only 0x10, change neither `pad_oe` nor `pad_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Raw pin input levels |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output level |

## Verification
Direction writes use sparse bit patterns that include pins 0 and 31, so that a strobe which overwrites instead of setting or clearing shows up in the untouched bits. Output writes use masks that differ from their value fields: a value bit with a clear mask exposes a missing mask, and writes to each half-bank expose swapped lanes or a shifted mask field. A level preloaded on an input pin that is then switched to output separates direction-independent storage from gated storage. An input pattern is sampled one and two edges after it changes, which pins down the synchronizer depth, and writes of all ones to unused and read-only addresses show whether the decode leaks.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned HALF_W   = 16;

    localparam int unsigned OFS_OE_SET  = 'h00;
    localparam int unsigned OFS_OE_CLR  = 'h04;
    localparam int unsigned OFS_LVL_LO  = 'h08;
    localparam int unsigned OFS_LVL_STP = 'h04;
    localparam int unsigned OFS_PIN_IN  = 'h10;

    typedef struct packed {
        logic oe_set;
        logic oe_clr;
        logic pin_rd;
        logic hit;
    } bank_dec_t;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/pinbank_dir.sv
module pinbank_dir #(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [NUM_PINS-1:0] sel,
    output logic [NUM_PINS-1:0] oe_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] oe;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) begin
            st_d.oe = st_q.oe | sel;
        end else if (clr_en) begin
            st_d.oe = st_q.oe & ~sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o = st_q.oe;

endmodule

// File: rtl/pinbank_lane.sv
module pinbank_lane #(
    parameter int unsigned LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] mask,
    input  logic [LANE_W-1:0] value,
    output logic [LANE_W-1:0] lvl_o
);

    typedef struct packed {
        logic [LANE_W-1:0] lvl;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.lvl = (st_q.lvl & ~mask) | (value & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
    import pinbank_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);

    localparam int unsigned LANES = NUM_PINS / HALF_W;

    bank_dec_t            dec;
    logic [LANES-1:0]     lane_sel;
    logic [NUM_PINS-1:0]  pin_sync;
    logic [NUM_PINS-1:0]  lvl_all;

    always_comb begin
        dec        = '0;
        lane_sel   = '0;
        dec.oe_set = (bus_addr == ADDR_W'(OFS_OE_SET));
        dec.oe_clr = (bus_addr == ADDR_W'(OFS_OE_CLR));
        dec.pin_rd = (bus_addr == ADDR_W'(OFS_PIN_IN));
        for (int l = 0; l < int'(LANES); l++) begin
            lane_sel[l] = (bus_addr == ADDR_W'(OFS_LVL_LO + l * OFS_LVL_STP));
        end
        dec.hit = dec.oe_set | dec.oe_clr | dec.pin_rd | (|lane_sel);
    end

    pinbank_dir #(
        .NUM_PINS (NUM_PINS)
    ) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr & dec.oe_set),
        .clr_en (bus_wr & dec.oe_clr),
        .sel    (bus_wdata[NUM_PINS-1:0]),
        .oe_o   (pad_oe)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pinbank_lane #(
            .LANE_W (HALF_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr & lane_sel[g]),
            .mask  (bus_wdata[DATA_W-1:HALF_W]),
            .value (bus_wdata[HALF_W-1:0]),
            .lvl_o (lvl_all[g*HALF_W +: HALF_W])
        );
    end

    pinbank_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (pin_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.oe_set || dec.oe_clr) begin
            bus_rdata = DATA_W'(pad_oe);
        end else if (dec.pin_rd) begin
            bus_rdata = DATA_W'(pin_sync);
        end else begin
            for (int l = 0; l < int'(LANES); l++) begin
                if (lane_sel[l]) begin
                    bus_rdata = DATA_W'(lvl_all[l*HALF_W +: HALF_W]);
                end
            end
        end
    end

    assign pad_out = lvl_all;

endmodule

// File: rtl/pinbank_port_chk.sv
module pinbank_port_chk
    import pinbank_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out
);

    logic [1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    logic known;
    assign known = (bus_addr == ADDR_W'(OFS_OE_SET)) || (bus_addr == ADDR_W'(OFS_OE_CLR))
                || (bus_addr == ADDR_W'(OFS_LVL_LO)) || (bus_addr == ADDR_W'(OFS_LVL_LO + OFS_LVL_STP))
                || (bus_addr == ADDR_W'(OFS_PIN_IN));

    a_r2_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_OE_SET))
        |=> pad_oe == ($past(pad_oe) | $past(bus_wdata[NUM_PINS-1:0])));

    a_r3_clr_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_OE_CLR))
        |=> pad_oe == ($past(pad_oe) & ~$past(bus_wdata[NUM_PINS-1:0])));

    a_r4_low_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_LVL_LO))
        |=> pad_out[15:0] == (($past(pad_out[15:0]) & ~$past(bus_wdata[31:16]))
                             | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    a_r5_high_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_LVL_LO + OFS_LVL_STP))
        |=> pad_out[31:16] == (($past(pad_out[31:16]) & ~$past(bus_wdata[31:16]))
                              | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    a_r6_level_kept_on_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(OFS_OE_SET) || bus_addr == ADDR_W'(OFS_OE_CLR)))
        |=> $stable(pad_out));

    a_r7_input_two_flops: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3 && bus_addr == ADDR_W'(OFS_PIN_IN))
        |-> bus_rdata == DATA_W'($past(pad_in, 2)));

    a_r8_level_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_LVL_LO) || bus_addr == ADDR_W'(OFS_LVL_LO + OFS_LVL_STP))
        |-> bus_rdata[31:16] == 16'h0);

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || !known || bus_addr == ADDR_W'(OFS_PIN_IN))
        |=> ($stable(pad_oe) && $stable(pad_out)));

    a_r9_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> bus_rdata == '0);

endmodule

bind pinbank_port pinbank_port_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/sim_pinbank_port.sv
module sim_pinbank_port;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 oe", pad_oe, 32'h0);
        check("R1 out", pad_out, 32'h0);
        bus_read(8'h08, r);
        check("R1 read low", r, 32'h0);
    endtask

    task automatic t_direction();
        logic [31:0] r;
        bus_write(8'h00, 32'h0000_00F0);
        check("R2 set", pad_oe, 32'h0000_00F0);
        bus_write(8'h00, 32'h8000_0001);
        check("R2 set merge", pad_oe, 32'h8000_00F1);
        bus_write(8'h04, 32'h0000_0030);
        check("R3 clear", pad_oe, 32'h8000_00C1);
        bus_read(8'h04, r);
        check("R8 read oe at clr addr", r, 32'h8000_00C1);
        bus_read(8'h00, r);
        check("R8 read oe at set addr", r, 32'h8000_00C1);
        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R3 clear all", pad_oe, 32'h0);
    endtask

    task automatic t_levels();
        logic [31:0] r;
        bus_write(8'h08, 32'h0005_FFFF);
        check("R4 masked set", pad_out, 32'h0000_0005);
        bus_write(8'h08, 32'h0001_0000);
        check("R4 single clear", pad_out, 32'h0000_0004);
        bus_read(8'h08, r);
        check("R8 read low", r, 32'h0000_0004);
        bus_write(8'h0C, 32'h8000_8000);
        check("R5 high set", pad_out, 32'h8000_0004);
        bus_write(8'h0C, 32'h0000_FFFF);
        check("R5 zero mask", pad_out, 32'h8000_0004);
        bus_read(8'h0C, r);
        check("R8 read high", r, 32'h0000_8000);
    endtask

    task automatic t_preload();
        bus_write(8'h0C, 32'h0010_0010);
        check("R6 preload level", pad_out, 32'h8010_0004);
        check("R6 still input", pad_oe, 32'h0);
        bus_write(8'h00, 32'h0010_0000);
        check("R6 oe rises", pad_oe, 32'h0010_0000);
        check("R6 level on enable", pad_out, 32'h8010_0004);
    endtask

    task automatic t_input();
        logic [31:0] r;
        @(negedge clk);
        pad_in = 32'hA5A5_1234;
        bus_addr = 8'h10;
        @(negedge clk);
        bus_read(8'h10, r);
        check("R7 one edge old", r, 32'h0);
        @(negedge clk);
        bus_read(8'h10, r);
        check("R7 two edges new", r, 32'hA5A5_1234);
    endtask

    task automatic t_unused();
        logic [31:0] r;
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h02, 32'hFFFF_FFFF);
        check("R9 oe untouched", pad_oe, 32'h0010_0000);
        check("R9 out untouched", pad_out, 32'h8010_0004);
        bus_read(8'h14, r);
        check("R9 read unused", r, 32'h0);
        bus_read(8'h01, r);
        check("R9 read misaligned", r, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_levels();
        t_preload();
        t_input();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule